// File: doc/BRIEF.md
# Storage-to-Storage Character String Engine

This block carries out one storage-to-storage character instruction at a time. A decoded 48-bit instruction arrives with a single-cycle start strobe. The engine reads two base registers through a pair of combinational register-file read ports and adds a 12-bit displacement to each one, which gives two 24-bit operand addresses. It then steps through the two byte strings in ascending address order on a byte-wide memory port.

The engine supports two operations. A move copies the string at the second operand over the string at the first operand. A compare examines both strings byte by byte and produces a two-bit condition code. While the loop runs, `busy` is high. When the last byte is finished, a single-cycle `done` pulse is raised and the condition code is presented on `cc`.

The memory port reads combinationally: `mem_rdata` must reflect `mem_addr` within the same cycle. A write strobed by `mem_we` takes effect at the next rising clock edge.

Top module: `ss_string_engine`

## Requirements
- R1: The instruction word is split as follows: opcode in bits 47:40, byte-count field in bits 39:32, first base selector in bits 31:28, first displacement in bits 27:16, second base selector in bits 15:12, second displacement in bits 11:0. Each operand address is the selected register value plus the zero-extended displacement, truncated to 24 bits. For a move, the first memory access of each byte is a read of the second operand. For a compare, it is a read of the first operand.
- R2: A base selector of 0 contributes zero to the address. The value held in register 0 is never used.
- R3: The byte-count field holds the number of bytes minus one. A value of 0 processes 1 byte and a value of 255 processes 256 bytes.
- R4: Opcode 8'hA1 is a move. For each byte, in ascending order, the engine reads the source byte in one cycle and writes it to the destination in the next cycle. This gives byte-by-byte propagation when the two operands overlap.
- R5: Opcode 8'hA5 is a compare of unsigned bytes. It stops after the first unequal pair. The result is cc = 0 if all bytes are equal, 1 if the first operand's byte is lower, and 2 if it is higher.
- R6: A compare never writes memory.
- R7: `busy` rises in the cycle after an accepted start. It stays high for exactly two cycles per byte processed. `done` then pulses for one cycle, with `busy` low.
- R8: A start is ignored while an instruction is in progress or being retired. A start whose opcode is neither 8'hA1 nor 8'hA5 is ignored. An ignored start causes no busy, no done and no memory access.
- R9: After reset, `busy`, `done`, `mem_rd` and `mem_we` are low and `cc` is 0. `cc` changes only in a done cycle, and a move leaves it unchanged.
- R10: Operand addresses wrap from 24'hFFFFFF to 24'h000000 as the loop advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to execute `instr` |
| instr | input | 48 | Decoded storage-to-storage instruction |
| rf_idx_a | output | 4 | Register index for the first base read |
| rf_val_a | input | 32 | Register value for `rf_idx_a` (combinational) |
| rf_idx_b | output | 4 | Register index for the second base read |
| rf_val_b | input | 32 | Register value for `rf_idx_b` (combinational) |
| mem_addr | output | 24 | Byte address for the current access |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read at `mem_addr` (combinational) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code, updated with `done` |

## Verification
Each internal fault shows up at the ports in a predictable way and within a bounded number of cycles.

A wrong pointer or a wrong base selection is visible on `mem_addr` at the first busy cycle. A wrong byte counter stretches or shortens `busy`, so it is caught on the cycle count as soon as `done` arrives. A wrong read/write ordering corrupts the destination image, which the bench compares in full after every instruction. A compare that stops too early or too late shows up both in the cycle count and in `cc` at the `done` pulse.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int INSTR_W = 48;
  localparam int OPC_W   = 8;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 4;
  localparam int DISP_W  = 12;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 24;
  localparam int BYTE_W  = 8;
  localparam int CC_W    = 2;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [CNT_W-1:0]  cnt;
    logic [SEL_W-1:0]  sel1;
    logic [DISP_W-1:0] disp1;
    logic [SEL_W-1:0]  sel2;
    logic [DISP_W-1:0] disp2;
  } ss_instr_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FIN    = 2'd3
  } ss_state_e;

  localparam logic [CC_W-1:0] CC_EQ   = 2'd0;
  localparam logic [CC_W-1:0] CC_LOW  = 2'd1;
  localparam logic [CC_W-1:0] CC_HIGH = 2'd2;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [SEL_W-1:0]  sel,
    input logic [REG_W-1:0]  base,
    input logic [DISP_W-1:0] disp
  );
    logic [ADDR_W-1:0] b;
    b = (sel == '0) ? '0 : base[ADDR_W-1:0];
    return b + ADDR_W'(disp);
  endfunction

  function automatic logic [CC_W-1:0] byte_order(
    input logic [BYTE_W-1:0] op1,
    input logic [BYTE_W-1:0] op2
  );
    if (op1 == op2)     return CC_EQ;
    else if (op1 < op2) return CC_LOW;
    else                return CC_HIGH;
  endfunction
endpackage

// File: rtl/ss_ea.sv
module ss_ea
  import ss_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [REG_W-1:0]  base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  always_comb ea = form_addr(sel, base, disp);
endmodule

// File: rtl/ss_cc_eval.sv
module ss_cc_eval
  import ss_pkg::*;
(
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  output logic              differ,
  output logic [CC_W-1:0]   code
);
  always_comb begin
    code   = byte_order(op1, op2);
    differ = (code != CC_EQ);
  end
endmodule

// File: rtl/ss_seq.sv
module ss_seq
  import ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              is_cmp,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] ea1,
  input  logic [ADDR_W-1:0] ea2,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic [CC_W-1:0]   cc,
  output logic              cmp_active,
  output logic              step_fire,
  output logic              mismatch_hit
);
  ss_state_e         state_q;
  logic [ADDR_W-1:0] a1_q, a2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cmp_q;
  logic [BYTE_W-1:0] hold_q;
  logic [CC_W-1:0]   cc_q;
  logic              differ;
  logic [CC_W-1:0]   code;
  logic              last_byte;

  ss_cc_eval u_cmp (
    .op1    (hold_q),
    .op2    (mem_rdata),
    .differ (differ),
    .code   (code)
  );

  always_comb begin
    idle         = (state_q == ST_IDLE);
    busy         = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    done         = (state_q == ST_FIN);
    step_fire    = (state_q == ST_SECOND);
    cmp_active   = busy && cmp_q;
    last_byte    = (cnt_q == '0);
    mismatch_hit = step_fire && cmp_q && differ;
    mem_rd       = (state_q == ST_FIRST) || (step_fire && cmp_q);
    mem_we       = step_fire && !cmp_q;
    mem_wdata    = hold_q;
    cc           = cc_q;
    if (state_q == ST_FIRST) mem_addr = cmp_q ? a1_q : a2_q;
    else                     mem_addr = cmp_q ? a2_q : a1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a1_q    <= '0;
      a2_q    <= '0;
      cnt_q   <= '0;
      cmp_q   <= 1'b0;
      hold_q  <= '0;
      cc_q    <= CC_EQ;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            a1_q    <= ea1;
            a2_q    <= ea2;
            cnt_q   <= cnt_in;
            cmp_q   <= is_cmp;
            state_q <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          hold_q  <= mem_rdata;
          state_q <= ST_SECOND;
        end
        ST_SECOND: begin
          a1_q  <= a1_q + 1'b1;
          a2_q  <= a2_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (mismatch_hit) begin
            cc_q    <= code;
            state_q <= ST_FIN;
          end else if (last_byte) begin
            if (cmp_q) cc_q <= CC_EQ;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_FIRST;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ss_string_engine.sv
module ss_string_engine
  import ss_pkg::*;
#(
  parameter logic [7:0] OPC_MOVE = 8'hA1,
  parameter logic [7:0] OPC_CMP  = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] instr,
  output logic [3:0]  rf_idx_a,
  input  logic [31:0] rf_val_a,
  output logic [3:0]  rf_idx_b,
  input  logic [31:0] rf_val_b,
  output logic [23:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [1:0]  cc
);
  ss_instr_t         ins;
  logic [ADDR_W-1:0] ea1, ea2;
  logic              opc_known, is_cmp, idle;
  logic              start_ok, cmp_active, step_fire, mismatch_hit;

  always_comb begin
    ins       = ss_instr_t'(instr);
    rf_idx_a  = ins.sel1;
    rf_idx_b  = ins.sel2;
    is_cmp    = (ins.opc == OPC_CMP);
    opc_known = is_cmp || (ins.opc == OPC_MOVE);
    start_ok  = start && idle && opc_known;
  end

  ss_ea u_ea1 (.sel(ins.sel1), .base(rf_val_a), .disp(ins.disp1), .ea(ea1));
  ss_ea u_ea2 (.sel(ins.sel2), .base(rf_val_b), .disp(ins.disp2), .ea(ea2));

  ss_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ok     (start_ok),
    .is_cmp       (is_cmp),
    .cnt_in       (ins.cnt),
    .ea1          (ea1),
    .ea2          (ea2),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .idle         (idle),
    .busy         (busy),
    .done         (done),
    .cc           (cc),
    .cmp_active   (cmp_active),
    .step_fire    (step_fire),
    .mismatch_hit (mismatch_hit)
  );
endmodule

// File: rtl/ss_string_engine_chk.sv
module ss_string_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  cc,
  input logic        mem_rd,
  input logic        mem_we,
  input logic [23:0] mem_addr,
  input logic        start_ok,
  input logic        cmp_active,
  input logic        step_fire,
  input logic        mismatch_hit
);
  AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we)); // R4
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_rd)); // R4
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_active |-> !mem_we); // R6
  AST_MISMATCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_hit |=> done); // R5
  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cc != 2'd3)); // R5
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_STEP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> busy); // R7
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_we)); // R8
  AST_CC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc) |-> done); // R9
  AST_WRITE_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we, 2)) |-> (mem_addr == $past(mem_addr, 2) + 24'd1)); // R10
endmodule

bind ss_string_engine ss_string_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .cc           (cc),
  .mem_rd       (mem_rd),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .start_ok     (start_ok),
  .cmp_active   (cmp_active),
  .step_fire    (step_fire),
  .mismatch_hit (mismatch_hit)
);

// File: tb/tb_ss_string_engine.sv
`timescale 1ns/1ps
module tb_ss_string_engine;
  localparam logic [7:0] OP_MV = 8'hA1;
  localparam logic [7:0] OP_CP = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] instr = '0;
  logic [3:0]  rf_idx_a, rf_idx_b;
  logic [31:0] rf_val_a, rf_val_b;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_we, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  cc;

  logic [31:0] rf [16];
  logic [7:0]  mem [4096];
  logic [7:0]  ref_mem [4096];
  int          n_tests = 0, n_fail = 0;
  int          low_writes = 0, mem_acc = 0;
  logic [1:0]  exp_cc = 2'd0;

  always #2 clk = ~clk;

  assign rf_val_a  = rf[rf_idx_a];
  assign rf_val_b  = rf[rf_idx_b];
  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_addr[23:12] == 12'd0) low_writes <= low_writes + 1;
    end
    if (mem_rd || mem_we) mem_acc <= mem_acc + 1;
  end

  ss_string_engine dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_ea(input logic [3:0] s, input logic [11:0] d);
    logic [31:0] v;
    v = (s == 4'd0) ? 32'd0 : rf[s];
    return 24'((v + {20'd0, d}) & 32'h00FF_FFFF);
  endfunction

  function automatic logic [47:0] mk(input logic [7:0] op, input logic [7:0] n,
      input logic [3:0] s1, input logic [11:0] d1, input logic [3:0] s2, input logic [11:0] d2);
    return {op, n, s1, d1, s2, d2};
  endfunction

  task automatic sync_mem();
    for (int i = 0; i < 4096; i++) mem[i] = ref_mem[i];
  endtask

  task automatic mem_compare(input string req);
    int bad = 0, where = 0;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== ref_mem[i]) begin
        if (bad == 0) where = i;
        bad++;
      end
    chk(bad == 0, req, "memory image mismatches (first index in actual)", where, 0);
  endtask

  // issue one instruction; returns busy cycles, done seen, address on first busy cycle
  task automatic issue(input logic [47:0] ins, output int bcyc, output bit seen,
                       output logic [23:0] first_a);
    @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_a = mem_addr;
    bcyc = 0;
    seen = 1'b0;
    for (int i = 0; i < 1200; i++) begin
      if (done) begin seen = 1'b1; break; end
      if (busy) bcyc++;
      @(negedge clk);
    end
  endtask

  // full instruction with reference model and all port checks
  task automatic run_op(input logic [47:0] ins, input string tag);
    logic [7:0]  op, n;
    logic [23:0] a1, a2, fa;
    int          nb, k, bc;
    bit          seen;
    logic [1:0]  c;
    op = ins[47:40];
    n  = ins[39:32];
    a1 = ref_ea(ins[31:28], ins[27:16]);
    a2 = ref_ea(ins[15:12], ins[11:0]);
    nb = int'(n) + 1;
    if (op == OP_MV) begin
      for (int i = 0; i < nb; i++)
        ref_mem[12'(a1 + 24'(i))] = ref_mem[12'(a2 + 24'(i))];
      k = nb;
    end else begin
      k = nb;
      c = 2'd0;
      for (int i = 0; i < nb; i++) begin
        logic [7:0] x, y;
        x = ref_mem[12'(a1 + 24'(i))];
        y = ref_mem[12'(a2 + 24'(i))];
        if (x != y) begin
          c = (x > y) ? 2'd2 : 2'd1;
          k = i + 1;
          break;
        end
      end
      exp_cc = c;
    end
    issue(ins, bc, seen, fa);
    chk(seen, "R7", {tag, " done pulse seen"}, seen, 1);
    chk(bc == 2 * k, "R3", {tag, " busy cycles (2 per byte)"}, bc, 2 * k);
    chk(fa == ((op == OP_MV) ? a2 : a1), "R1", {tag, " first address"}, fa,
        (op == OP_MV) ? a2 : a1);
    chk(cc == exp_cc, (op == OP_MV) ? "R9" : "R5", {tag, " condition code"}, cc, exp_cc);
    @(negedge clk);
    chk(!done && !busy, "R7", {tag, " done lasts one cycle"}, {done, busy}, 0);
    mem_compare((op == OP_MV) ? "R4" : "R6");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bc, acc0;
    bit seen;
    logic [23:0] fa;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'($urandom);
    sync_mem();

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !mem_rd && !mem_we && cc == 2'd0, "R9", "reset outputs",
        {busy, done, mem_rd, mem_we, cc}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: base selector 0 ignores register 0
    rf[0] = 32'h0000_0800;
    run_op(mk(OP_MV, 8'd7, 4'd0, 12'h100, 4'd0, 12'h200), "base0 move");

    // R3: single byte and 256-byte moves
    rf[5] = 32'h0000_0300;
    run_op(mk(OP_MV, 8'd0, 4'd5, 12'h010, 4'd6, 12'h020), "len0 move");
    run_op(mk(OP_MV, 8'd255, 4'd5, 12'h000, 4'd7, 12'h123), "len255 move");

    // R1: displacement carry into upper address bits
    rf[3] = 32'h1234_5F80;
    run_op(mk(OP_MV, 8'd4, 4'd3, 12'hFFF, 4'd5, 12'h400), "carry move");

    // R4: overlapping move propagates the first byte
    run_op(mk(OP_MV, 8'd9, 4'd0, 12'h601, 4'd0, 12'h600), "overlap move");

    // R5: compare equal, low at first byte, high at last byte
    for (int i = 0; i < 8; i++) ref_mem[12'h700 + i] = ref_mem[12'h780 + i];
    sync_mem();
    run_op(mk(OP_CP, 8'd7, 4'd0, 12'h700, 4'd0, 12'h780), "cmp equal");
    ref_mem[12'h700] = 8'h10; ref_mem[12'h780] = 8'hF0;
    sync_mem();
    run_op(mk(OP_CP, 8'd7, 4'd0, 12'h700, 4'd0, 12'h780), "cmp low first");
    ref_mem[12'h700] = 8'h33; ref_mem[12'h780] = 8'h33;
    ref_mem[12'h707] = 8'h90; ref_mem[12'h787] = 8'h7F;
    sync_mem();
    run_op(mk(OP_CP, 8'd7, 4'd0, 12'h700, 4'd0, 12'h780), "cmp high last");

    // R9: a move after a compare keeps cc
    run_op(mk(OP_MV, 8'd2, 4'd0, 12'h900, 4'd0, 12'h950), "move keeps cc");

    // R8: unknown opcode is ignored
    acc0 = mem_acc;
    @(negedge clk);
    instr = mk(8'h00, 8'd3, 4'd0, 12'h100, 4'd0, 12'h200);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit any = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (busy || done) any = 1'b1;
        @(negedge clk);
      end
      chk(!any, "R8", "unknown opcode raised busy/done", any, 0);
    end
    chk(mem_acc == acc0, "R8", "unknown opcode memory accesses", mem_acc - acc0, 0);
    mem_compare("R8");

    // R8: second start while busy is ignored
    for (int i = 0; i < 16; i++) ref_mem[12'hA00 + i] = ref_mem[12'hB00 + i];
    @(negedge clk);
    instr = mk(OP_MV, 8'd15, 4'd0, 12'hA00, 4'd0, 12'hB00);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    instr = mk(OP_MV, 8'd15, 4'd0, 12'hC00, 4'd0, 12'hD00);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R8", "start during busy launched a second run", busy, 0);
    mem_compare("R8");

    // R10: address wrap at 24 bits
    rf[1] = 32'h00FF_FFF0;
    low_writes = 0;
    run_op(mk(OP_MV, 8'd3, 4'd1, 12'h00E, 4'd0, 12'h300), "wrap move");
    chk(low_writes == 2, "R10", "writes landing after wrap", low_writes, 2);

    // random mix of move and compare
    for (int t = 0; t < 40; t++) begin
      logic [7:0]  op, n;
      logic [3:0]  s1, s2;
      logic [11:0] d1, d2;
      for (int i = 0; i < 16; i++) rf[i] = $urandom;
      op = ($urandom % 2) ? OP_MV : OP_CP;
      n  = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 24);
      s1 = 4'($urandom); s2 = 4'($urandom);
      d1 = 12'($urandom); d2 = 12'($urandom);
      if (op == OP_CP) begin
        logic [23:0] a1, a2;
        a1 = ref_ea(s1, d1);
        a2 = ref_ea(s2, d2);
        for (int i = 0; i <= int'(n); i++)
          ref_mem[12'(a1 + 24'(i))] = ref_mem[12'(a2 + 24'(i))];
        if ($urandom % 3 != 0) begin
          int p;
          p = $urandom % (int'(n) + 1);
          ref_mem[12'(a1 + 24'(p))] = 8'($urandom);
        end
        sync_mem();
      end
      run_op(mk(op, n, s1, d1, s2, d2), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule